// File: doc/BRIEF.md
# Multidrop Express Channel Drop-Off Tap

A unidirectional express channel runs along one row or column of a tiled network. One source drives it, and any number of downstream nodes may take packets off it. This block is the tap that sits at one such node. The channel carries wormhole packets made of flits. The tap reads the destination field of each head flit only, and from that makes a single steering choice for the whole packet. The packet either drops into the local node's input queue or is repeated unchanged onto the next channel segment. A packet that drops locally is never driven further down the channel, so the wire past its destination stays quiet.

The tap is purely combinational on the data path and holds one small steering register per packet. Its three flit interfaces use valid/ready handshakes: the incoming channel, the local sink and the downstream segment. Because the tap works at any position along the chain, its node address is a parameter. A head flit may also carry a broadcast flag. With that flag, the tap hands the packet to the local node and passes it on at the same time. This is the first hop of a two-hop row-then-column broadcast. In that case each flit transfers only when both sides accept it together.

Flit layout, most significant bits first: a 2-bit type, one broadcast bit, a NODE_W-bit destination, and DATA_W data bits.

Top module: `mdtap_top`

## Requirements
- R1: After synchronous reset no packet is open. The first flit that is not a head goes downstream only.
- R2: A head flit whose destination equals NODE_ID and whose broadcast bit is 0 is offered on the local side only. dn_valid stays low.
- R3: A head flit whose destination differs from NODE_ID and whose broadcast bit is 0 is offered downstream only. loc_valid stays low.
- R4: Every later flit of a packet follows the head's choice, whatever its own destination and broadcast bits hold.
- R5: Transfer of a tail (type 2'b10) or single-flit (type 2'b11) flit closes the packet. The next head is decoded afresh.
- R6: When the broadcast bit of a head is 1, every flit of the packet goes to both sides. Each side's valid is raised only while the other side is ready, so a flit is accepted only when both take it in the same cycle.
- R7: in_ready equals the ready of the selected side, or the AND of both sides for a broadcast. A side that is not selected never sees a valid flit.
- R8: A non-head flit (type 2'b00 body or 2'b10 tail) that arrives with no packet open is repeated downstream.
- R9: The flit appears unchanged on every side whose valid is high, in the same cycle it is presented.
- R10: Type encoding: 2'b00 body, 2'b01 head, 2'b10 tail, 2'b11 head and tail of a one-flit packet. Type bit 0 marks a packet start and type bit 1 marks a packet end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming channel flit valid |
| in_ready | output | 1 | Tap accepts the incoming flit |
| in_flit | input | DATA_W+NODE_W+3 | Incoming flit |
| loc_valid | output | 1 | Flit offered to the local node |
| loc_ready | input | 1 | Local node accepts |
| loc_flit | output | DATA_W+NODE_W+3 | Flit to the local node |
| dn_valid | output | 1 | Flit offered to the next segment |
| dn_ready | input | 1 | Next segment accepts |
| dn_flit | output | DATA_W+NODE_W+3 | Flit to the next segment |

## Verification
The assertions assume a well-formed incoming stream. Each head is followed by body flits and then a tail, or it stands alone as a single-flit packet. A flit that has been presented stays in place until it is accepted. The stimulus generator builds whole packets of one to four flits, holds valid and the flit steady while the tap stalls, and starts a new packet only after the previous one has closed. Body flits carry random destination and broadcast bits so that any re-decoding would show. The one deliberately orphaned body flit is sent just after reset, where R8 defines its treatment.

// File: rtl/mdtap_pkg.sv
package mdtap_pkg;

    // R10: flit type codes; bit 0 opens a packet, bit 1 closes it
    typedef enum logic [1:0] {
        FT_BODY = 2'b00,
        FT_HEAD = 2'b01,
        FT_TAIL = 2'b10,
        FT_SOLO = 2'b11
    } ftype_e;

    typedef struct packed {
        logic to_loc;
        logic to_dn;
    } route_t;

    localparam route_t ROUTE_PASS = '{to_loc: 1'b0, to_dn: 1'b1};
    localparam route_t ROUTE_DROP = '{to_loc: 1'b1, to_dn: 1'b0};
    localparam route_t ROUTE_BOTH = '{to_loc: 1'b1, to_dn: 1'b1};

    function automatic logic opens_pkt(input logic [1:0] t);
        return t[0];
    endfunction

    function automatic logic closes_pkt(input logic [1:0] t);
        return t[1];
    endfunction

endpackage

// File: rtl/mdtap_decode.sv
module mdtap_decode
    import mdtap_pkg::*;
#(
    parameter int NODE_W   = 3,
    parameter int NODE_ID  = 0,
    parameter bit BCAST_EN = 1'b1
) (
    input  logic [NODE_W-1:0] dest,
    input  logic              bcast,
    output route_t            route
);
    localparam logic [NODE_W-1:0] MY_ADDR = NODE_W'(NODE_ID);

    logic hit;
    assign hit = (dest == MY_ADDR);

    generate
        if (BCAST_EN) begin : g_bcast
            always_comb begin
                if (bcast)    route = ROUTE_BOTH;
                else if (hit) route = ROUTE_DROP;
                else          route = ROUTE_PASS;
            end
        end else begin : g_unicast
            logic bcast_unused;
            assign bcast_unused = bcast;
            always_comb begin
                route = hit ? ROUTE_DROP : ROUTE_PASS;
            end
        end
    endgenerate
endmodule

// File: rtl/mdtap_steer.sv
module mdtap_steer
    import mdtap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ftype,
    input  logic       xfer,
    input  route_t     head_route,
    output route_t     cur_route
);
    logic   open_q;
    route_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            held_q <= ROUTE_PASS;
        end else if (xfer) begin
            if (closes_pkt(ftype)) begin
                open_q <= 1'b0;
            end else if (opens_pkt(ftype)) begin
                open_q <= 1'b1;
                held_q <= head_route;
            end
        end
    end

    always_comb begin
        if (opens_pkt(ftype)) cur_route = head_route;
        else if (open_q)      cur_route = held_q;
        else                  cur_route = ROUTE_PASS;
    end
endmodule

// File: rtl/mdtap_fanout.sv
module mdtap_fanout
    import mdtap_pkg::*;
(
    input  logic   in_valid,
    input  route_t route,
    input  logic   loc_ready,
    input  logic   dn_ready,
    output logic   loc_valid,
    output logic   dn_valid,
    output logic   in_ready
);
    logic loc_ok;
    logic dn_ok;

    // a side that is not selected never holds up the transfer
    assign loc_ok    = !route.to_loc || loc_ready;
    assign dn_ok     = !route.to_dn  || dn_ready;
    assign in_ready  = loc_ok && dn_ok;
    assign loc_valid = in_valid && route.to_loc && dn_ok;
    assign dn_valid  = in_valid && route.to_dn  && loc_ok;
endmodule

// File: rtl/mdtap_top.sv
module mdtap_top
    import mdtap_pkg::*;
#(
    parameter int NODE_W   = 3,
    parameter int DATA_W   = 16,
    parameter int NODE_ID  = 5,
    parameter bit BCAST_EN = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [DATA_W+NODE_W+2:0] in_flit,
    output logic                     loc_valid,
    input  logic                     loc_ready,
    output logic [DATA_W+NODE_W+2:0] loc_flit,
    output logic                     dn_valid,
    input  logic                     dn_ready,
    output logic [DATA_W+NODE_W+2:0] dn_flit
);
    localparam int FW     = DATA_W + NODE_W + 3;
    localparam int DST_LO = DATA_W;
    localparam int BC_POS = DATA_W + NODE_W;

    logic [1:0]        ftype;
    logic [NODE_W-1:0] dest;
    logic              bcast;
    route_t            head_route;
    route_t            cur_route;
    logic              xfer;

    assign ftype = in_flit[FW-1 -: 2];
    assign dest  = in_flit[DST_LO +: NODE_W];
    assign bcast = in_flit[BC_POS];
    assign xfer  = in_valid && in_ready;

    mdtap_decode #(
        .NODE_W  (NODE_W),
        .NODE_ID (NODE_ID),
        .BCAST_EN(BCAST_EN)
    ) decode_i (
        .dest (dest),
        .bcast(bcast),
        .route(head_route)
    );

    mdtap_steer steer_i (
        .clk       (clk),
        .rst       (rst),
        .ftype     (ftype),
        .xfer      (xfer),
        .head_route(head_route),
        .cur_route (cur_route)
    );

    mdtap_fanout fanout_i (
        .in_valid (in_valid),
        .route    (cur_route),
        .loc_ready(loc_ready),
        .dn_ready (dn_ready),
        .loc_valid(loc_valid),
        .dn_valid (dn_valid),
        .in_ready (in_ready)
    );

    assign loc_flit = in_flit;
    assign dn_flit  = in_flit;
endmodule

// File: rtl/mdtap_chk.sv
module mdtap_chk #(
    parameter int NODE_W  = 3,
    parameter int NODE_ID = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_type,
    input logic              in_bc,
    input logic [NODE_W-1:0] in_dest,
    input logic              loc_valid,
    input logic              loc_ready,
    input logic              dn_valid,
    input logic              dn_ready
);
    localparam logic [NODE_W-1:0] MY_ADDR = NODE_W'(NODE_ID);

    a_r2_unicast_local_only: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_type[0] && !in_bc && in_dest == MY_ADDR) |-> !dn_valid);

    a_r3_miss_not_local: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_type[0] && !in_bc && in_dest != MY_ADDR) |-> !loc_valid);

    a_r4_local_held: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && loc_valid && !dn_valid && !in_type[1]) |=> !dn_valid);

    a_r6_both_sides_ready: assert property (@(posedge clk) disable iff (rst)
        (loc_valid && dn_valid) |-> (loc_ready && dn_ready && in_ready));

    a_r7_no_loss: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (loc_valid || dn_valid));

    a_r7_no_dup_local: assert property (@(posedge clk) disable iff (rst)
        (loc_valid && loc_ready) |-> in_ready);

    a_r7_no_dup_down: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_ready) |-> in_ready);
endmodule

bind mdtap_top mdtap_chk #(
    .NODE_W (NODE_W),
    .NODE_ID(NODE_ID)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_type  (in_flit[DATA_W+NODE_W+2 -: 2]),
    .in_bc    (in_flit[DATA_W+NODE_W]),
    .in_dest  (in_flit[DATA_W +: NODE_W]),
    .loc_valid(loc_valid),
    .loc_ready(loc_ready),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready)
);

// File: tb/mdtap_tb.sv
`timescale 1ns/1ps
module mdtap_top_tb_top;
    localparam int NODE_W  = 3;
    localparam int DATA_W  = 16;
    localparam int NODE_ID = 5;
    localparam int FW      = DATA_W + NODE_W + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [FW-1:0] in_flit = '0;
    logic          loc_valid;
    logic          loc_ready = 1'b0;
    logic [FW-1:0] loc_flit;
    logic          dn_valid;
    logic          dn_ready = 1'b0;
    logic [FW-1:0] dn_flit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model of the steering state
    bit       m_open  = 1'b0;
    bit [1:0] m_route = 2'b01;   // {loc, dn}

    // stimulus generator state
    int                g_left = 0;
    logic [NODE_W-1:0] g_dest = '0;
    logic              g_bc   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mdtap_top #(.NODE_W(NODE_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID), .BCAST_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_flit(loc_flit),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_flit(dn_flit)
    );

    // R10: type in the top two bits, then broadcast bit, destination, data
    function automatic logic [FW-1:0] mk(input logic [1:0] t, input logic bc,
                                         input logic [NODE_W-1:0] d, input logic [DATA_W-1:0] x);
        return {t, bc, d, x};
    endfunction

    function automatic bit [1:0] decode(input logic [FW-1:0] f);
        if (f[DATA_W+NODE_W]) return 2'b11;
        return (f[DATA_W +: NODE_W] == NODE_WIDTH_ID()) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [NODE_W-1:0] NODE_WIDTH_ID();
        return NODE_W'(NODE_ID);
    endfunction

    task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check before posedge, update model at posedge
    task automatic cycle(input logic v, input logic [FW-1:0] f, input logic lr,
                         input logic dr, output bit acc);
        bit [1:0] r;
        bit       lok;
        bit       dok;
        string    tag;
        @(negedge clk);
        in_valid  = v;
        in_flit   = f;
        loc_ready = lr;
        dn_ready  = dr;
        #1;
        if (f[FW-2])      r = decode(f);
        else if (m_open)  r = m_route;
        else              r = 2'b01;
        if (f[FW-2])      tag = (r == 2'b11) ? "R6" : (r == 2'b10) ? "R2" : "R3";
        else              tag = m_open ? ((r == 2'b11) ? "R6" : "R4") : "R8";
        lok = !r[1] || lr;
        dok = !r[0] || dr;
        check({tag, " loc_valid"}, FW'(loc_valid), FW'(v && r[1] && dok));
        check({tag, " dn_valid"},  FW'(dn_valid),  FW'(v && r[0] && lok));
        check("R7 in_ready", FW'(in_ready), FW'(lok && dok));
        if (loc_valid) check("R9 loc_flit", loc_flit, f);
        if (dn_valid)  check("R9 dn_flit",  dn_flit,  f);
        acc = v && lok && dok;
        @(posedge clk);
        if (acc) begin
            if (f[FW-1])      m_open = 1'b0;   // R5 close
            else if (f[FW-2]) begin m_open = 1'b1; m_route = decode(f); end
        end
    endtask

    function automatic logic [FW-1:0] next_flit();
        logic [1:0] t;
        if (g_left == 0) begin
            g_left = 1 + int'($urandom % 4);
            g_dest = ($urandom % 5 < 2) ? NODE_WIDTH_ID() : NODE_W'($urandom);
            g_bc   = ($urandom % 5 == 0);
            t = (g_left == 1) ? 2'b11 : 2'b01;
            g_left--;
            return mk(t, g_bc, g_dest, DATA_W'($urandom));
        end
        g_left--;
        t = (g_left == 0) ? 2'b10 : 2'b00;
        // body and tail carry random routing bits: R4 says they are ignored
        return mk(t, 1'(($urandom)), NODE_W'($urandom), DATA_W'($urandom));
    endfunction

    initial begin
        bit            acc;
        logic [FW-1:0] cur;
        logic          curv;
        logic          lr;
        logic          dr;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        // R1: outputs quiet under reset with nothing presented
        @(negedge clk);
        check("R1 loc_valid in reset", FW'(loc_valid), '0);
        check("R1 dn_valid in reset",  FW'(dn_valid),  '0);
        rst = 1'b0;
        // R1/R8: orphan body after reset goes downstream
        cycle(1'b1, mk(2'b00, 1'b0, NODE_WIDTH_ID(), 16'hA5A5), 1'b1, 1'b1, acc);
        // R2/R7: local head stalled by local sink
        cycle(1'b1, mk(2'b01, 1'b0, NODE_WIDTH_ID(), 16'h1111), 1'b0, 1'b1, acc);
        cycle(1'b1, mk(2'b01, 1'b0, NODE_WIDTH_ID(), 16'h1111), 1'b1, 1'b0, acc);
        // R4: body addressed elsewhere still drops locally
        cycle(1'b1, mk(2'b00, 1'b1, 3'd2, 16'h2222), 1'b1, 1'b1, acc);
        cycle(1'b1, mk(2'b10, 1'b0, 3'd1, 16'h3333), 1'b1, 1'b1, acc);
        // R5: next head after tail decoded afresh (miss -> R3)
        cycle(1'b1, mk(2'b11, 1'b0, 3'd0, 16'h4444), 1'b1, 1'b1, acc);
        // R6: broadcast single flit, one side stalled then both ready
        cycle(1'b1, mk(2'b11, 1'b1, 3'd0, 16'h5555), 1'b1, 1'b0, acc);
        cycle(1'b1, mk(2'b11, 1'b1, 3'd0, 16'h5555), 1'b0, 1'b1, acc);
        cycle(1'b1, mk(2'b11, 1'b1, 3'd0, 16'h5555), 1'b1, 1'b1, acc);
        // random packets with valid held under backpressure
        curv = 1'b0;
        cur  = '0;
        acc  = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if (!(curv && !acc)) begin
                curv = ($urandom % 5) != 0;
                if (curv) cur = next_flit();
            end
            lr = ($urandom % 10) < 7;
            dr = ($urandom % 10) < 7;
            cycle(curv, cur, lr, dr, acc);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule